// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a physical address. When paging is switched on, it reads two 32-bit entries from memory. The first is a directory entry, found at the root base plus the ten highest address bits. The second is a table entry, found in the 4 KB page table that the directory entry names, indexed by the next ten address bits. The block checks each entry for presence and for user access. It then returns either a physical address or a page fault. A fault carries the faulting linear address and the level where the walk stopped. When paging is off, the linear address is returned unchanged and no memory is read.

A requester raises `req_valid` for one cycle while `busy` is low. It receives exactly one result pulse: `done_valid` or `fault_valid`. Memory reads use a simple request/ready port. The read request holds until the memory answers with `mem_rd_ready` and the entry on `mem_rd_data`. Only one walk is in flight at a time. Requests made while a walk is running are dropped.

Top module: `pg_walker`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_rd_en`, `done_valid` and `fault_valid` are all low.
- R2: A request accepted with `pg_en` low gives `done_valid` with `done_phys` equal to the linear address in the next cycle, with no memory read.
- R3: With `pg_en` high, the first read address is the root base bits 31:12, then linear bits 31:22, then two zero bits.
- R4: After a usable directory entry, the second read address is entry bits 31:12, then linear bits 21:12, then two zero bits.
- R5: After a usable table entry, `done_valid` pulses in the cycle after the read completes, with `done_phys` equal to table entry bits 31:12 joined with linear bits 11:0.
- R6: A directory entry with bit 0 (present) clear gives `fault_valid` with `fault_lin` equal to the request address and `fault_at_table` low. No table read is made.
- R7: A table entry with bit 0 clear gives `fault_valid` with `fault_at_table` high and `fault_lin` equal to the request address.
- R8: A request with `req_user` high passes a level only if bit 2 (user) of that entry is set; otherwise it faults at that level. A request with `req_user` low ignores bit 2.
- R9: While `mem_rd_ready` is low, `mem_rd_en` stays high and `mem_rd_addr` stays stable.
- R10: While `busy` is high, `req_valid` and a changed `pg_en` have no effect on the walk or on its result.
- R11: `done_valid` and `fault_valid` are never high together, and each is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request, taken when `busy` is low |
| req_lin | input | 32 | Linear address to translate |
| req_user | input | 1 | 1 = least privileged requester, 0 = most privileged |
| pg_en | input | 1 | Paging enable |
| root_base | input | 32 | Directory base; bits 31:12 are used |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_ready | input | 1 | Read data valid; the read completes this cycle |
| mem_rd_data | input | 32 | Entry read from memory |
| busy | output | 1 | A walk is in progress or its result is showing |
| done_valid | output | 1 | One-cycle translation success pulse |
| done_phys | output | 32 | Physical address, valid with `done_valid` |
| fault_valid | output | 1 | One-cycle page fault pulse |
| fault_lin | output | 32 | Faulting linear address, valid with `fault_valid` |
| fault_at_table | output | 1 | 0 = fault at directory level, 1 = at table level |

## Verification
A request is accepted on one clock edge. The directory read shows in the next cycle. With paging off, the result shows in that same next cycle instead. Each read stays up for as many cycles as the memory stalls. The table read, or a directory-level fault, appears in the cycle after the edge where `mem_rd_ready` was high. The final result follows the table read one cycle later in the same way, and `busy` falls one cycle after that. The bench drives every input on the falling edge and samples at the following falling edge. It mirrors that count exactly: it checks the read address in every stall cycle, checks the result in the cycle after the completing edge, and checks for quiet outputs one cycle later.

// File: rtl/pgw_pkg.sv
// Shared types for the page translation walker.
package pgw_pkg;
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DIR,
        WS_TBL,
        WS_DONE,
        WS_FAULT
    } walk_state_t;
endpackage

// File: rtl/pgw_addr_gen.sv
// Forms the entry read address for the current walk level.
// Assumes entries are 2^ENT_SH bytes and tables are page aligned.
module pgw_addr_gen #(
    parameter int FRAME_W = 20,
    parameter int IDX_W   = 10,
    parameter int ENT_SH  = 2
) (
    input  logic                          at_table,
    input  logic [FRAME_W-1:0]            root_frame,
    input  logic [FRAME_W-1:0]            dir_frame,
    input  logic [IDX_W-1:0]              dir_idx,
    input  logic [IDX_W-1:0]              tbl_idx,
    output logic [FRAME_W+IDX_W+ENT_SH-1:0] rd_addr
);
    // pick base frame and index for the level being read
    always_comb begin
        if (at_table)
            rd_addr = {dir_frame, tbl_idx, {ENT_SH{1'b0}}};
        else
            rd_addr = {root_frame, dir_idx, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/pgw_entry_chk.sv
// Decodes one directory/table entry: present and user-permission check.
// Assumes the entry arrives whole on the memory data bus.
module pgw_entry_chk #(
    parameter int ADDR_W   = 32,
    parameter int OFS_W    = 12,
    parameter int PRES_BIT = 0,
    parameter int USER_BIT = 2
) (
    input  logic [ADDR_W-1:0]       entry,
    input  logic                    user_req,
    output logic                    usable,
    output logic [ADDR_W-OFS_W-1:0] frame
);
    logic unused_flag_bits;

    // usable when present and, for user requests, marked user
    always_comb begin
        usable = entry[PRES_BIT] && (!user_req || entry[USER_BIT]);
        frame  = entry[ADDR_W-1:OFS_W];
    end

    assign unused_flag_bits = ^entry[OFS_W-1:0];
endmodule

// File: rtl/pgw_ctrl.sv
// Walk sequencer: accepts a request, steps through the directory and table
// reads, holds the walk context and produces the result registers.
// Assumes the memory answers each read with a one-cycle ready pulse.
module pgw_ctrl
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12,
    localparam int FRAME_W = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               req_user,
    input  logic               pg_en,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               rd_ready,
    input  logic               ent_usable,
    input  logic [FRAME_W-1:0] ent_frame,
    output walk_state_t        state,
    output logic [ADDR_W-1:0]  lin_q,
    output logic               user_q,
    output logic [FRAME_W-1:0] root_q,
    output logic [FRAME_W-1:0] dir_q,
    output logic [ADDR_W-1:0]  phys_q,
    output logic               fault_tbl_q
);
    // state transitions and context capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WS_IDLE;
            lin_q       <= '0;
            user_q      <= 1'b0;
            root_q      <= '0;
            dir_q       <= '0;
            phys_q      <= '0;
            fault_tbl_q <= 1'b0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        lin_q  <= req_lin;
                        user_q <= req_user;
                        root_q <= root_frame;
                        if (pg_en) begin
                            state <= WS_DIR;
                        end else begin
                            phys_q <= req_lin;
                            state  <= WS_DONE;
                        end
                    end
                end
                WS_DIR: begin
                    if (rd_ready) begin
                        if (ent_usable) begin
                            dir_q <= ent_frame;
                            state <= WS_TBL;
                        end else begin
                            fault_tbl_q <= 1'b0;
                            state       <= WS_FAULT;
                        end
                    end
                end
                WS_TBL: begin
                    if (rd_ready) begin
                        if (ent_usable) begin
                            phys_q <= {ent_frame, lin_q[OFS_W-1:0]};
                            state  <= WS_DONE;
                        end else begin
                            fault_tbl_q <= 1'b1;
                            state       <= WS_FAULT;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pg_walker.sv
// Two-level page translation walker top. Wires the sequencer, the address
// former and the entry checker. Assumes ADDR_W == OFS_W + 2*IDX_W.
module pg_walker
    import pgw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFS_W    = 12,
    parameter int IDX_W    = 10,
    parameter int PRES_BIT = 0,
    parameter int USER_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin,
    input  logic              req_user,
    input  logic              pg_en,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_phys,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_lin,
    output logic              fault_at_table
);
    localparam int FRAME_W = ADDR_W - OFS_W;
    localparam int ENT_SH  = OFS_W - IDX_W;

    walk_state_t        state;
    logic [ADDR_W-1:0]  lin_q;
    logic               user_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] dir_q;
    logic [ADDR_W-1:0]  phys_q;
    logic               fault_tbl_q;
    logic               ent_usable;
    logic [FRAME_W-1:0] ent_frame;
    logic               unused_root_low;

    pgw_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_lin    (req_lin),
        .req_user   (req_user),
        .pg_en      (pg_en),
        .root_frame (root_base[ADDR_W-1:OFS_W]),
        .rd_ready   (mem_rd_ready),
        .ent_usable (ent_usable),
        .ent_frame  (ent_frame),
        .state      (state),
        .lin_q      (lin_q),
        .user_q     (user_q),
        .root_q     (root_q),
        .dir_q      (dir_q),
        .phys_q     (phys_q),
        .fault_tbl_q(fault_tbl_q)
    );

    pgw_addr_gen #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)) u_addr (
        .at_table  (state == WS_TBL),
        .root_frame(root_q),
        .dir_frame (dir_q),
        .dir_idx   (lin_q[ADDR_W-1 -: IDX_W]),
        .tbl_idx   (lin_q[OFS_W+IDX_W-1 -: IDX_W]),
        .rd_addr   (mem_rd_addr)
    );

    pgw_entry_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W),
                    .PRES_BIT(PRES_BIT), .USER_BIT(USER_BIT)) u_chk_ent (
        .entry   (mem_rd_data),
        .user_req(user_q),
        .usable  (ent_usable),
        .frame   (ent_frame)
    );

    // decode outputs from the walk state and result registers
    always_comb begin
        mem_rd_en      = (state == WS_DIR) || (state == WS_TBL);
        busy           = (state != WS_IDLE);
        done_valid     = (state == WS_DONE);
        fault_valid    = (state == WS_FAULT);
        done_phys      = phys_q;
        fault_lin      = lin_q;
        fault_at_table = fault_tbl_q;
    end

    assign unused_root_low = ^root_base[OFS_W-1:0];
endmodule

// File: rtl/pgw_checker.sv
// Protocol checker for pg_walker, attached by bind.
module pgw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_lin,
    input logic              pg_en,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ready,
    input logic              done_valid,
    input logic [ADDR_W-1:0] done_phys,
    input logic              fault_valid
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !done_valid && !fault_valid)); // R1
    AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !pg_en) |=> (done_valid && done_phys == $past(req_lin) && !mem_rd_en)); // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rd_ready) |=> (mem_rd_en && $stable(mem_rd_addr))); // R9
    AST_WALK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_valid && !fault_valid) |=> busy); // R10
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R11
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid); // R11
endmodule

bind pg_walker pgw_checker #(.ADDR_W(ADDR_W)) u_pgw_checker (.*);

// File: tb/sim_pg_walker.sv
module sim_pg_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_user, pg_en, mem_rd_ready;
    logic [31:0] req_lin, root_base, mem_rd_data;
    logic        mem_rd_en, busy, done_valid, fault_valid, fault_at_table;
    logic [31:0] mem_rd_addr, done_phys, fault_lin;
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    pg_walker u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // watchdog: ends a hung run as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog R11 act=%h exp=%h", busy, 1'b0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic bit entry_ok(input logic [31:0] e, input bit user);
        return e[0] && (!user || e[2]);
    endfunction

    // serve one entry read with lat stall cycles; starts at a negedge where the read is up
    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data, input int lat,
                         input bit junk, input string tag);
        for (int i = 0; i < lat; i++) begin
            chk(mem_rd_en === 1'b1 && mem_rd_addr === exp_addr, "R9", mem_rd_addr, exp_addr);
            mem_rd_data = $urandom;
            if (junk) begin
                req_valid = 1'b1;
                req_lin   = $urandom;
                pg_en     = $urandom;
                req_user  = $urandom;
            end
            @(negedge clk);
        end
        chk(mem_rd_en === 1'b1 && mem_rd_addr === exp_addr, tag, mem_rd_addr, exp_addr);
        req_valid    = 1'b0;
        mem_rd_ready = 1'b1;
        mem_rd_data  = data;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        mem_rd_data  = $urandom;
    endtask

    task automatic walk(input logic [31:0] lin, input logic [31:0] cr3, input logic [31:0] pde,
                        input logic [31:0] pte, input bit user, input bit pgon,
                        input int lat1, input int lat2, input bit junk);
        logic [31:0] a1, a2, phys;
        bit ok1, ok2;
        string ftag;
        a1  = {cr3[31:12], lin[31:22], 2'b00};
        a2  = {pde[31:12], lin[21:12], 2'b00};
        phys = {pte[31:12], lin[11:0]};
        ok1 = entry_ok(pde, user);
        ok2 = entry_ok(pte, user);
        req_valid = 1'b1; req_lin = lin; req_user = user; pg_en = pgon; root_base = cr3;
        @(negedge clk);
        req_valid = 1'b0;
        if (!pgon) begin
            chk(done_valid === 1'b1 && done_phys === lin && mem_rd_en === 1'b0, "R2", done_phys, lin);
        end else begin
            serve(a1, pde, lat1, junk, "R3");
            if (!ok1) begin
                ftag = pde[0] ? "R8" : "R6";
                chk(fault_valid === 1'b1 && done_valid === 1'b0 && fault_at_table === 1'b0 &&
                    fault_lin === lin && mem_rd_en === 1'b0, ftag, fault_lin, lin);
            end else begin
                serve(a2, pte, lat2, junk, "R4");
                if (!ok2) begin
                    ftag = pte[0] ? "R8" : "R7";
                    chk(fault_valid === 1'b1 && done_valid === 1'b0 && fault_at_table === 1'b1 &&
                        fault_lin === lin, ftag, fault_lin, lin);
                end else begin
                    chk(done_valid === 1'b1 && fault_valid === 1'b0 && done_phys === phys,
                        junk ? "R10" : "R5", done_phys, phys);
                end
            end
        end
        @(negedge clk);
        chk(done_valid === 1'b0 && fault_valid === 1'b0 && busy === 1'b0, "R11",
            {30'd0, done_valid, fault_valid}, 32'd0);
    endtask

    initial begin
        logic [31:0] pde, pte;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; req_valid = 1'b0; req_lin = '0; req_user = 1'b0; pg_en = 1'b0;
        root_base = '0; mem_rd_ready = 1'b0; mem_rd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mem_rd_en === 1'b0 && done_valid === 1'b0 && fault_valid === 1'b0,
            "R1", {28'd0, busy, mem_rd_en, done_valid, fault_valid}, 32'd0);

        // directed corner cases
        walk(32'hDEAD_BEEF, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 0, 0, 1'b0);            // R2
        walk(32'h1234_5678, 32'h0010_0ABC, 32'h0020_0006, 32'h0, 1'b0, 1'b1, 0, 0, 1'b0); // R6
        walk(32'hFFC0_0FFF, 32'h0030_0000, 32'h0040_0007, 32'h0050_0006, 1'b1, 1'b1, 1, 2, 1'b0); // R7
        walk(32'h0040_1000, 32'h0060_0000, 32'h0070_0003, 32'h0080_0007, 1'b1, 1'b1, 0, 0, 1'b0); // R8 dir
        walk(32'h0040_1000, 32'h0060_0000, 32'h0070_0007, 32'h0080_0003, 1'b1, 1'b1, 0, 0, 1'b0); // R8 table
        walk(32'h0040_1ABC, 32'h0060_0000, 32'h0070_0001, 32'h0080_0001, 1'b0, 1'b1, 2, 0, 1'b0); // R8 supervisor
        walk(32'hAAAA_5555, 32'hFFFF_F000, 32'h1357_9007, 32'h2468_A005, 1'b1, 1'b1, 3, 3, 1'b1); // R10

        // constrained random walks
        for (int n = 0; n < 300; n++) begin
            pde = $urandom; pde[0] = ($urandom % 8) != 0; pde[2] = ($urandom % 4) != 0;
            pte = $urandom; pte[0] = ($urandom % 8) != 0; pte[2] = ($urandom % 4) != 0;
            walk($urandom, $urandom, pde, pte, $urandom, ($urandom % 6) != 0,
                 $urandom % 4, $urandom % 4, ($urandom % 5) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule